// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

The controller gathers fifteen request lines (numbered 1 to 15) for a single processor and turns them into a 4-bit interrupt level. Each rising edge on a line either sets a bit in a shared pending register or, if software has marked that line for broadcast, sets the line's bit in the force register of every CPU slot. For CPU 0 the enabled set is the union of pending and CPU-0 force, masked by the CPU-0 mask. A software tier register splits the enabled set into an urgent group, whose tier bit is 1, and a normal group, whose tier bit is 0. The urgent group is always served first. The level output names the highest-numbered line in the group being served.

The processor acknowledges an interrupt by pulsing an acknowledge strobe with the interrupt number. This clears that line in pending and in CPU-0 force. Software reaches the registers through a 32-bit word port with an 8-bit address. The port accepts a request every cycle and returns read data one cycle later. Mask, force and extended registers exist for each of up to 16 CPU slots, but only slot 0 drives the level output.

Top module: `irq_tier_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_level_o` is 0 and `bus_ready_o` is 1.
- R2: Request inputs pass through a two-stage synchroniser and rising-edge detection. A rising edge on line n (n from 1 to 15) with broadcast bit n clear sets pending bit n. A line held high sets the bit only once. Input bit 0 is ignored.
- R3: A rising edge on line n with broadcast bit n set sets bit n in the force register of every CPU slot and leaves pending unchanged. The broadcast register is at 0x14.
- R4: The enabled set is (pending | force of slot 0) & mask of slot 0. If the enabled bits that have their tier bit set (tier register at 0x00) are non-empty, `irq_level_o` is the highest-numbered of them. Otherwise it is the highest-numbered enabled bit. It is 0 when nothing is enabled. The output is registered: it reflects the register state one cycle earlier.
- R5: An acknowledge with number n (taken mod 16) clears pending bit n and slot-0 force bit n. A new request edge on the same line in the same cycle wins, and the bit stays set.
- R6: A write to the slot-c force register at 0x80+4c computes (old | value[15:1]) & ~value[31:17] on bits 15:1. A write to 0x08 replaces slot-0 force with value[15:1]. Address 0x08 also reads slot-0 force.
- R7: A write to 0x0C clears the pending bits that are 1 in value[15:1]. Pending reads at 0x04. Reads of 0x0C and 0x10 return zero. Writes to 0x04 and 0x10 change nothing.
- R8: Bit 0 of the tier, broadcast, mask, force and pending registers is always 0, whatever is written.
- R9: The slot-c mask is at 0x40+4c. The slot-c extended register at 0xC0+4c keeps value[3:0]. Reads of undecoded or non-word-aligned addresses return zero, and writes to them change nothing.
- R10: Only full-word accesses (`bus_be_i` = 4'hF) act. A partial write changes nothing, and a partial read returns zero.
- R11: Every accepted read (`bus_valid_i` & ~`bus_write_i`) gives `rsp_valid_o` high in the next cycle with the data. `rsp_valid_o` is low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 16 | Request lines, bit n is line n, bit 0 unused |
| ack_valid_i | input | 1 | Acknowledge strobe from the processor |
| ack_num_i | input | 4 | Number of the interrupt being acknowledged |
| irq_level_o | output | 4 | Presented interrupt level, 0 = none |
| bus_valid_i | input | 1 | Register access request valid |
| bus_ready_o | output | 1 | Access accepted; always high, no back-pressure |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address in the 256-byte window |
| bus_be_i | input | 4 | Byte enables; only 4'hF performs an access |
| bus_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read; the requester must take it |
| rsp_rdata_o | output | 32 | Read data |

## Verification
The tier selector is swept with several hundred pseudo-random combinations of slot-0 force, mask and tier words. Each combination is compared with a level computed arithmetically in the bench. This separates the urgent-first choice from a plain highest-bit choice and shows that masked bits are ignored. Each request line is pulsed in turn and also held high, which separates edge detection from level sensing. Broadcast-marked lines are checked in all sixteen force slots to tell broadcast from pending routing. An acknowledge that lines up with a fresh edge on the same line checks that the edge wins. Combined set/clear force words, bit-0 writes, partial byte enables, read-only and undecoded addresses check that each write path changes only the bits it should.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQ_W = 16;
  localparam int LVL_W = 4;
  typedef logic [IRQ_W-1:0] vec_t;
  localparam vec_t LINE_MASK = {{(IRQ_W-1){1'b1}}, 1'b0};

  localparam logic [7:0] A_TIER   = 8'h00;
  localparam logic [7:0] A_PEND   = 8'h04;
  localparam logic [7:0] A_FALIAS = 8'h08;
  localparam logic [7:0] A_CLR    = 8'h0C;
  localparam logic [7:0] A_MPST   = 8'h10;
  localparam logic [7:0] A_BCAST  = 8'h14;

  typedef enum logic [1:0] {
    RG_GLOBAL = 2'd0,
    RG_MASK   = 2'd1,
    RG_FORCE  = 2'd2,
    RG_EXT    = 2'd3
  } region_e;

  function automatic logic [LVL_W-1:0] top_index(vec_t v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 1; i < IRQ_W; i++)
      if (v[i]) r = LVL_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/irqc_req_sync.sv
module irqc_req_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] rise_o
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_line
      logic [STAGES-1:0] sh_q;
      logic              last_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q   <= '0;
          last_q <= 1'b0;
        end else begin
          sh_q   <= {sh_q[STAGES-2:0], raw_i[i]};
          last_q <= sh_q[STAGES-1];
        end
      end
      assign rise_o[i] = sh_q[STAGES-1] & ~last_q;
    end
  endgenerate
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile import irqc_pkg::*; #(
  parameter int NUM_CPU = 16,
  parameter int EXT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  vec_t             rise_i,
  input  logic             ack_valid_i,
  input  logic [LVL_W-1:0] ack_num_i,
  output logic [31:0]      rdata_o,
  output vec_t             tier_o,
  output vec_t             pend_o,
  output vec_t             force0_o,
  output vec_t             mask0_o
);
  region_e    region;
  logic [3:0] slot;
  logic       aligned;
  assign region  = region_e'(addr_i[7:6]);
  assign slot    = addr_i[5:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  logic wr_tier, wr_falias, wr_clr, wr_bcast;
  assign wr_tier   = wr_en_i && (addr_i == A_TIER);
  assign wr_falias = wr_en_i && (addr_i == A_FALIAS);
  assign wr_clr    = wr_en_i && (addr_i == A_CLR);
  assign wr_bcast  = wr_en_i && (addr_i == A_BCAST);

  vec_t wlo, whi, ack_bits, lines, to_pend, to_force;
  vec_t tier_q, pend_q, bcast_q;
  assign wlo      = wdata_i[15:0] & LINE_MASK;
  assign whi      = wdata_i[31:16] & LINE_MASK;
  assign ack_bits = ack_valid_i ? ((vec_t'(1) << ack_num_i) & LINE_MASK) : '0;
  assign lines    = rise_i & LINE_MASK;
  assign to_pend  = lines & ~bcast_q;
  assign to_force = lines & bcast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tier_q  <= '0;
      bcast_q <= '0;
      pend_q  <= '0;
    end else begin
      if (wr_tier)  tier_q  <= wlo;
      if (wr_bcast) bcast_q <= wlo;
      pend_q <= (pend_q & ~(wr_clr ? wlo : '0) & ~ack_bits) | to_pend;
    end
  end

  vec_t             mask_w  [NUM_CPU];
  vec_t             force_w [NUM_CPU];
  logic [EXT_W-1:0] ext_w   [NUM_CPU];

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic             hit_mask, hit_force, hit_ext;
      vec_t             mask_r, force_r, force_nxt;
      logic [EXT_W-1:0] ext_r;
      assign hit_mask  = wr_en_i && aligned && region == RG_MASK  && slot == 4'(c);
      assign hit_force = wr_en_i && aligned && region == RG_FORCE && slot == 4'(c);
      assign hit_ext   = wr_en_i && aligned && region == RG_EXT   && slot == 4'(c);

      always_comb begin
        force_nxt = force_r;
        if (hit_force) force_nxt = (force_r | wlo) & ~whi;
        if (c == 0) begin
          if (wr_falias) force_nxt = wlo;
          force_nxt = force_nxt & ~ack_bits;
        end
        force_nxt = force_nxt | to_force;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_r  <= '0;
          force_r <= '0;
          ext_r   <= '0;
        end else begin
          if (hit_mask) mask_r <= wlo;
          if (hit_ext)  ext_r  <= wdata_i[EXT_W-1:0];
          force_r <= force_nxt;
        end
      end
      assign mask_w[c]  = mask_r;
      assign force_w[c] = force_r;
      assign ext_w[c]   = ext_r;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (region)
        RG_GLOBAL: begin
          case (addr_i)
            A_TIER:   rdata_o = 32'(tier_q);
            A_PEND:   rdata_o = 32'(pend_q);
            A_FALIAS: rdata_o = 32'(force_w[0]);
            A_BCAST:  rdata_o = 32'(bcast_q);
            default:  rdata_o = '0;
          endcase
        end
        RG_MASK:
          for (int c = 0; c < NUM_CPU; c++)
            if (slot == 4'(c)) rdata_o = 32'(mask_w[c]);
        RG_FORCE:
          for (int c = 0; c < NUM_CPU; c++)
            if (slot == 4'(c)) rdata_o = 32'(force_w[c]);
        RG_EXT:
          for (int c = 0; c < NUM_CPU; c++)
            if (slot == 4'(c)) rdata_o = 32'(ext_w[c]);
        default: rdata_o = '0;
      endcase
    end
  end

  assign tier_o   = tier_q;
  assign pend_o   = pend_q;
  assign force0_o = force_w[0];
  assign mask0_o  = mask_w[0];
endmodule

// File: rtl/irqc_tier_sel.sv
module irqc_tier_sel import irqc_pkg::*; (
  input  vec_t             pend_i,
  input  vec_t             force0_i,
  input  vec_t             mask0_i,
  input  vec_t             tier_i,
  output logic [LVL_W-1:0] level_o
);
  vec_t enabled, urgent, normal;
  assign enabled = (pend_i | force0_i) & mask0_i;
  assign urgent  = enabled & tier_i;
  assign normal  = enabled & ~tier_i;
  assign level_o = top_index((|urgent) ? urgent : normal);
endmodule

// File: rtl/irq_tier_ctrl.sv
module irq_tier_ctrl import irqc_pkg::*; #(
  parameter int NUM_CPU     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] irq_req_i,
  input  logic             ack_valid_i,
  input  logic [LVL_W-1:0] ack_num_i,
  output logic [LVL_W-1:0] irq_level_o,
  input  logic             bus_valid_i,
  output logic             bus_ready_o,
  input  logic             bus_write_i,
  input  logic [7:0]       bus_addr_i,
  input  logic [3:0]       bus_be_i,
  input  logic [31:0]      bus_wdata_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_rdata_o
);
  localparam logic [3:0] FULL_BE = 4'hF;

  logic             full_word, wr_en, rd_acc;
  logic [31:0]      rd_data;
  vec_t             rise_w, tier_w, pend_w, force0_w, mask0_w;
  logic [LVL_W-1:0] level_nxt;

  assign bus_ready_o = 1'b1;
  assign full_word   = (bus_be_i == FULL_BE);
  assign wr_en       = bus_valid_i & bus_write_i & full_word;
  assign rd_acc      = bus_valid_i & ~bus_write_i;

  irqc_req_sync #(.W(IRQ_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (irq_req_i),
    .rise_o (rise_w)
  );

  irqc_regfile #(.NUM_CPU(NUM_CPU), .EXT_W(EXT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rise_i      (rise_w),
    .ack_valid_i (ack_valid_i),
    .ack_num_i   (ack_num_i),
    .rdata_o     (rd_data),
    .tier_o      (tier_w),
    .pend_o      (pend_w),
    .force0_o    (force0_w),
    .mask0_o     (mask0_w)
  );

  irqc_tier_sel u_sel (
    .pend_i   (pend_w),
    .force0_i (force0_w),
    .mask0_i  (mask0_w),
    .tier_i   (tier_w),
    .level_o  (level_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level_o <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      irq_level_o <= level_nxt;
      rsp_valid_o <= rd_acc;
      if (rd_acc) rsp_rdata_o <= full_word ? rd_data : '0;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker import irqc_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [7:0]       bus_addr,
  input logic [3:0]       bus_be,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic [LVL_W-1:0] irq_level,
  input logic             ack_valid,
  input logic [LVL_W-1:0] ack_num,
  input vec_t             rise,
  input vec_t             pend,
  input vec_t             force0,
  input vec_t             mask0
);
  a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);

  a_r11_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rsp_valid);

  a_r10_partial_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_be != 4'hF) |=> (rsp_rdata == 32'h0));

  a_r7_clear_status_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && (bus_addr == A_CLR || bus_addr == A_MPST)) |=> (rsp_rdata == 32'h0));

  a_r4_idle_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend | force0) & mask0) == '0) |=> (irq_level == '0));

  a_r5_ack_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !rise[ack_num]) |=> !pend[$past(ack_num)]);

  a_r8_no_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend[0] && !force0[0] && !mask0[0]));
endmodule

bind irq_tier_ctrl irqc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid_i),
  .bus_write (bus_write_i),
  .bus_addr  (bus_addr_i),
  .bus_be    (bus_be_i),
  .rsp_valid (rsp_valid_o),
  .rsp_rdata (rsp_rdata_o),
  .irq_level (irq_level_o),
  .ack_valid (ack_valid_i),
  .ack_num   (ack_num_i),
  .rise      (rise_w),
  .pend      (pend_w),
  .force0    (force0_w),
  .mask0     (mask0_w)
);

// File: tb/tb_irq_tier_ctrl.sv
module tb_irq_tier_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_num = '0;
  logic [3:0]  irq_level;
  logic        bus_valid = 1'b0, bus_ready, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_tier_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .ack_valid_i(ack_valid),
    .ack_num_i(ack_num), .irq_level_o(irq_level), .bus_valid_i(bus_valid),
    .bus_ready_o(bus_ready), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_be_i(bus_be), .bus_wdata_i(bus_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp,
                        input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_valid = 1'b0; bus_be = 4'hF;
    check({tag, " (R11 rsp_valid)"}, 32'(rsp_valid), 32'd1);
    check(tag, rsp_rdata, exp);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); irq_req[n] = 1'b1;
    repeat (5) @(negedge clk);
    irq_req[n] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ack(input int n);
    @(negedge clk); ack_valid = 1'b1; ack_num = 4'(n);
    @(negedge clk); ack_valid = 1'b0;
  endtask

  function automatic logic [3:0] expect_level(logic [15:0] f, logic [15:0] m, logic [15:0] t);
    logic [15:0] en, g;
    logic [3:0] r;
    en = f & m & 16'hFFFE;
    g = ((en & t) != 0) ? (en & t) : (en & ~t);
    r = 0;
    for (int i = 1; i < 16; i++) if (g[i]) r = 4'(i);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf, f, m, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 level after reset", 32'(irq_level), 0);
    check("R1 ready", 32'(bus_ready), 1);
    for (int a = 0; a < 256; a += 4) rd_chk("R1 reset read", 8'(a), 0);

    // R8 bit 0 forced low
    wr(8'h00, 32'hFFFF_FFFF); rd_chk("R8 tier bit0", 8'h00, 32'h0000_FFFE);
    wr(8'h14, 32'hFFFF_FFFF); rd_chk("R8 bcast bit0", 8'h14, 32'h0000_FFFE);
    wr(8'h40, 32'hFFFF_FFFF); rd_chk("R8 mask bit0", 8'h40, 32'h0000_FFFE);
    wr(8'h08, 32'hFFFF_FFFF); rd_chk("R8 alias bit0", 8'h08, 32'h0000_FFFE);
    wr(8'h00, 0); wr(8'h14, 0); wr(8'h08, 0); wr(8'h40, 0);

    // R4 tier selection sweep
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      f = lf; lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      m = lf; lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      t = lf; lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (k % 3 == 0) m = 16'hFFFF;
      wr(8'h40, 32'(m)); wr(8'h00, 32'(t)); wr(8'h08, 32'(f));
      @(negedge clk);
      check("R4 tier sweep level", 32'(irq_level), 32'(expect_level(f, m, t)));
    end
    wr(8'h08, 0); wr(8'h00, 0); wr(8'h40, 32'h0000_FFFE);
    @(negedge clk);
    check("R4 nothing enabled", 32'(irq_level), 0);

    // R2 each line sets pending by edge
    for (int n = 1; n < 16; n++) begin
      pulse(n);
      rd_chk("R2 pending set", 8'h04, 32'(1) << n);
      check("R4 single line level", 32'(irq_level), 32'(n));
      wr(8'h0C, 32'(1) << n);
      rd_chk("R7 clear pending", 8'h04, 0);
    end
    pulse(0);
    rd_chk("R2 line 0 ignored", 8'h04, 0);
    @(negedge clk); irq_req[3] = 1'b1;
    repeat (5) @(negedge clk);
    wr(8'h0C, 32'h8);
    repeat (6) @(negedge clk);
    rd_chk("R2 held line sets once", 8'h04, 0);
    irq_req[3] = 1'b0;

    // R7 read-only and zero-read registers
    pulse(6);
    wr(8'h04, 0);
    rd_chk("R7 pending write ignored", 8'h04, 32'h40);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R7 status reads zero", 8'h10, 0);
    rd_chk("R7 clear reads zero", 8'h0C, 0);
    rd_chk("R7 pending after status write", 8'h04, 32'h40);

    // R5 acknowledge
    pulse(9);
    @(negedge clk);
    check("R5 level before ack", 32'(irq_level), 9);
    ack(9);
    @(negedge clk);
    check("R5 level after ack", 32'(irq_level), 6);
    rd_chk("R5 pending after ack", 8'h04, 32'h40);
    ack(6 + 16);
    rd_chk("R5 ack clears", 8'h04, 0);
    pulse(11);
    @(negedge clk); irq_req[11] = 1'b1;
    @(negedge clk);
    @(negedge clk); ack_valid = 1'b1; ack_num = 4'd11;
    @(negedge clk); ack_valid = 1'b0;
    rd_chk("R5 same-cycle request wins", 8'h04, 32'h800);
    irq_req[11] = 1'b0;
    ack(11);
    rd_chk("R5 cleared after plain ack", 8'h04, 0);

    // R3 broadcast
    wr(8'h14, 32'h20);
    pulse(5);
    rd_chk("R3 pending untouched", 8'h04, 0);
    for (int c = 0; c < 16; c++) rd_chk("R3 force in every slot", 8'(8'h80 + 4 * c), 32'h20);
    @(negedge clk);
    check("R3 level from force", 32'(irq_level), 5);
    ack(5);
    rd_chk("R5 ack clears slot-0 force", 8'h80, 0);
    rd_chk("R5 ack leaves slot-1 force", 8'h84, 32'h20);
    wr(8'h14, 0);

    // R6 force set/clear and alias
    for (int c = 0; c < 16; c++) begin
      wr(8'(8'h80 + 4 * c), 32'hFFFE_0000);
      rd_chk("R6 force full clear", 8'(8'h80 + 4 * c), 0);
      wr(8'(8'h80 + 4 * c), 32'h0000_F0F0);
      wr(8'(8'h80 + 4 * c), 32'h3030_000E);
      rd_chk("R6 force set and clear", 8'(8'h80 + 4 * c), 32'h0000_C0CE);
    end
    wr(8'h08, 32'hFFFF_1235);
    rd_chk("R6 alias replace", 8'h80, 32'h1234);
    rd_chk("R6 alias read", 8'h08, 32'h1234);

    // R9 mask slots, extended and undecoded
    for (int c = 0; c < 16; c++) begin
      wr(8'(8'h40 + 4 * c), 32'(16'h1111 * (c % 4 + 1)));
      wr(8'(8'hC0 + 4 * c), 32'hFFFF_FFF0 | 32'(c));
    end
    for (int c = 0; c < 16; c++) begin
      rd_chk("R9 mask slot", 8'(8'h40 + 4 * c), 32'(16'h1111 * (c % 4 + 1)) & 32'hFFFE);
      rd_chk("R9 extended low bits", 8'(8'hC0 + 4 * c), 32'(c));
    end
    for (int a = 8'h18; a < 8'h40; a += 4) begin
      wr(8'(a), 32'hFFFF_FFFF);
      rd_chk("R9 undecoded reads zero", 8'(a), 0);
    end
    rd_chk("R9 unaligned reads zero", 8'h41, 0);

    // R10 partial accesses
    wr(8'h40, 32'h0000_FFFE);
    wr(8'h40, 0, 4'h3);
    rd_chk("R10 partial write ignored", 8'h40, 32'hFFFE);
    rd_chk("R10 partial read zero", 8'h40, 0, 4'h1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule